// File: doc/BRIEF.md
# Round-Robin Shared-Bus Arbiter

This block decides which of sixteen bus masters owns a shared, pipelined system bus. Each master raises its own request line. The arbiter drives a one-hot grant vector and a 4-bit master number that steers the address and control multiplexers. Priority rotates: after a master wins, the master that follows it in index order becomes the first one searched. When nobody is requesting, the bus is parked on master 0.

Once the owner starts a transfer, a small controller holds the grant. A beat counter counts beats that the selected slave accepts (ready high) until the latched burst length is reached. An error response also ends the transfer. Re-arbitration happens only when the transfer ends, or when an owner with no active transfer drops its request. The new grant and the new master number appear on the same clock edge that ends the transfer, so there is no dead cycle between owners.

Top module: `arb_rr_bus`

## Requirements
- R1: At every clock after reset, exactly one bit of `grant` is high, and `master_num` equals the index of that bit.
- R2: While `rst` is high at a rising edge, the next state has master 0 granted, `master_num` = 0, `xfer_busy` = 0 and `xfer_done` = 0.
- R3: If no transfer is active, the owner is not requesting, and no request line is high, master 0 is granted at the next edge.
- R4: Arbitration searches the request lines starting at the index after the last master granted through a request, and wraps from 15 to 0. A grant to master 0 as the parked default does not move this starting point.
- R5: A handover takes effect on the same edge that ends the old owner's transfer. `grant` and `master_num` change together, with no cycle in which no owner is granted.
- R6: With no transfer active, if the owner's request is high and `xfer_start` is high, `xfer_busy` rises at the next edge and `burst_len` is latched. A latched length of 0 behaves as 1.
- R7: While `xfer_busy` is high, `grant` does not change, whatever the request lines do, until the transfer ends.
- R8: A beat completes on an edge where `xfer_busy` and `hready` are high and `hresp` is 00. The transfer ends on the edge that completes beat number `burst_len`. `hready` low stalls the count. `xfer_done` is high for exactly the one cycle after the ending edge, and `xfer_busy` is low in that cycle.
- R9: A nonzero `hresp` with `hready` high during a transfer ends the transfer at that edge, whatever the beat count.
- R10: With no transfer active, if the owner's request is low, the arbiter re-arbitrates at the next edge. In that case `xfer_start` is ignored.
- R11: With no transfer active, an owner that keeps its request high without starting a transfer keeps the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 16 | One request line per master |
| xfer_start | input | 1 | Owner begins a transfer this cycle |
| burst_len | input | 5 | Beats in the transfer being started (0 acts as 1) |
| hready | input | 1 | Selected slave accepts the current beat |
| hresp | input | 2 | Slave response, 00 = okay, anything else = error |
| grant | output | 16 | One-hot grant, registered |
| master_num | output | 4 | Index of the granted master, registered |
| xfer_busy | output | 1 | A transfer is in progress |
| xfer_done | output | 1 | One-cycle pulse after a transfer ends |

## Verification
A corrupted rotation pointer shows up at the next contended arbitration as the wrong `master_num`, one edge after the ending beat. That makes the long rotation pass, in which all sixteen masters request, sensitive to any off-by-one. A beat counter that miscounts moves `xfer_done` and the handover edge by at least one cycle, and the scoreboard catches that directly. If the controller state leaks, the grant moves in the middle of a burst, or a held owner loses the bus while idle, and this is visible in the very next sample.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // two-state controller; a single-bit code changes one bit per transition
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } xfer_st_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] start_idx,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W:0] N_EXT = (IDX_W+1)'(N);

  logic [IDX_W:0] pos;

  always_comb begin
    any = 1'b0;
    idx = '0;
    pos = '0;
    for (int k = 0; k < N; k++) begin
      pos = {1'b0, start_idx} + (IDX_W+1)'(k);
      if (pos >= N_EXT) pos = pos - N_EXT;
      if (!any && req[pos[IDX_W-1:0]]) begin
        any = 1'b1;
        idx = pos[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/arb_onehot_enc.sv
module arb_onehot_enc #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] num
);
  logic [N-1:0] sel [IDX_W];

  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    for (genvar i = 0; i < N; i++) begin : g_src
      if (((i >> b) % 2) == 1) begin : g_on
        assign sel[b][i] = onehot[i];
      end else begin : g_off
        assign sel[b][i] = 1'b0;
      end
    end
    assign num[b] = |sel[b];
  end
endmodule

// File: rtl/arb_xfer_ctrl.sv
module arb_xfer_ctrl
  import arb_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             owner_req,
  input  logic             xfer_start,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             hready,
  input  logic [1:0]       hresp,
  output logic             busy,
  output logic             arb_en,
  output logic             done_now
);
  xfer_st_t         state_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W:0]   beat_no;
  logic             beat_last;
  logic             err;

  assign beat_no   = {1'b0, cnt_q} + (LEN_W+1)'(1);
  assign beat_last = beat_no >= {1'b0, len_q};
  assign err       = hresp != RESP_OKAY;
  assign done_now  = (state_q == ST_BUSY) && hready && (err || beat_last);
  assign arb_en    = ((state_q == ST_IDLE) && !owner_req) || done_now;
  assign busy      = state_q == ST_BUSY;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (owner_req && xfer_start) begin
            state_q <= ST_BUSY;
            len_q   <= burst_len;
            cnt_q   <= '0;
          end
        end
        default: begin
          if (done_now) state_q <= ST_IDLE;
          else if (hready) cnt_q <= cnt_q + LEN_W'(1);
        end
      endcase
    end
  end

  // R6: an accepted start opens a transfer with a cleared beat count
  a_r6_start_opens: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && owner_req && xfer_start) |=> (state_q == ST_BUSY && cnt_q == '0));

  // R8: a stalled beat leaves the count and the state untouched
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY && !hready) |=> (state_q == ST_BUSY && $stable(cnt_q)));

  // R9: an error response closes the transfer at once
  a_r9_error_ends: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY && hready && hresp != RESP_OKAY) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/arb_rr_bus.sv
module arb_rr_bus #(
  parameter int N         = 16,
  parameter int LEN_W     = 5,
  parameter int DEFAULT_M = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 xfer_start,
  input  logic [LEN_W-1:0]     burst_len,
  input  logic                 hready,
  input  logic [1:0]           hresp,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] master_num,
  output logic                 xfer_busy,
  output logic                 xfer_done
);
  localparam int             IDX_W   = $clog2(N);
  localparam logic [N-1:0]   DEF_OH  = N'(1) << DEFAULT_M;
  localparam logic [IDX_W-1:0] DEF_IDX = IDX_W'(DEFAULT_M);
  localparam logic [IDX_W-1:0] PTR_RST = (DEFAULT_M == N - 1) ? '0 : IDX_W'(DEFAULT_M + 1);

  logic [N-1:0]     grant_q;
  logic [IDX_W-1:0] num_q;
  logic [IDX_W-1:0] ptr_q;
  logic             done_q;

  logic             owner_req;
  logic             arb_en;
  logic             done_now;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic [N-1:0]     next_grant;
  logic [IDX_W-1:0] next_num;

  assign owner_req = |(req & grant_q);

  arb_xfer_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .owner_req  (owner_req),
    .xfer_start (xfer_start),
    .burst_len  (burst_len),
    .hready     (hready),
    .hresp      (hresp),
    .busy       (xfer_busy),
    .arb_en     (arb_en),
    .done_now   (done_now)
  );

  arb_rr_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .req       (req),
    .start_idx (ptr_q),
    .any       (pick_any),
    .idx       (pick_idx)
  );

  assign next_grant = pick_any ? (N'(1) << pick_idx) : DEF_OH;

  arb_onehot_enc #(.N(N), .IDX_W(IDX_W)) u_enc (
    .onehot (next_grant),
    .num    (next_num)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= DEF_OH;
      num_q   <= DEF_IDX;
      ptr_q   <= PTR_RST;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_now;
      if (arb_en) begin
        grant_q <= next_grant;
        num_q   <= next_num;
        if (pick_any) ptr_q <= (pick_idx == IDX_W'(N - 1)) ? '0 : pick_idx + IDX_W'(1);
      end
    end
  end

  assign grant      = grant_q;
  assign master_num = num_q;
  assign xfer_done  = done_q;

  // R1: grant always one-hot
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst) $onehot(grant_q));

  // R1: encoded number names the granted bit
  a_r1_num_match: assert property (@(posedge clk) disable iff (rst) grant_q[num_q]);

  // R2: reset parks the bus on the default master, controller idle
  a_r2_reset_state: assert property (@(posedge clk)
    rst |=> (grant_q == DEF_OH && num_q == DEF_IDX && !xfer_busy && !done_q));

  // R3: idle bus with no requests falls back to the default master
  a_r3_default: assert property (@(posedge clk) disable iff (rst)
    (!xfer_busy && req == '0) |=> (grant_q == DEF_OH));

  // R7: grant frozen while a transfer continues
  a_r7_hold_mid_xfer: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy && !hready) |=> $stable(grant_q));

  // R8: done pulse never overlaps a busy cycle
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !xfer_busy);
endmodule

// File: tb/arb_rr_bus_bench.sv
module arb_rr_bus_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req = '0;
  logic        xfer_start = 1'b0;
  logic [4:0]  burst_len = '0;
  logic        hready = 1'b0;
  logic [1:0]  hresp = 2'b00;
  logic [15:0] grant;
  logic [3:0]  master_num;
  logic        xfer_busy;
  logic        xfer_done;

  always #2 clk = ~clk;  // 250 MHz

  arb_rr_bus u_arb_rr_bus (
    .clk(clk), .rst(rst), .req(req), .xfer_start(xfer_start),
    .burst_len(burst_len), .hready(hready), .hresp(hresp),
    .grant(grant), .master_num(master_num),
    .xfer_busy(xfer_busy), .xfer_done(xfer_done)
  );

  typedef struct {
    int    owner;
    bit    busy;
    bit    done;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 1'b0;

  task automatic compare(input exp_t e);
    logic [15:0] eg;
    eg = 16'(1) << e.owner;
    n_checks++;
    if (grant !== eg || master_num !== 4'(e.owner) ||
        xfer_busy !== e.busy || xfer_done !== e.done) begin
      n_fail++;
      $display("FAIL %s: grant=%h num=%0d busy=%b done=%b expected grant=%h num=%0d busy=%b done=%b",
               e.tag, grant, master_num, xfer_busy, xfer_done, eg, e.owner, e.busy, e.done);
    end
  endtask

  // monitor: one expectation per clock, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  // driver: apply inputs, queue the result expected after the next edge
  task automatic step(input logic [15:0] rq, input logic st, input int ln,
                      input logic rdy, input logic [1:0] rsp,
                      input int eo, input bit eb, input bit ed, input string tag);
    exp_t e;
    req = rq; xfer_start = st; burst_len = 5'(ln); hready = rdy; hresp = rsp;
    e.owner = eo; e.busy = eb; e.done = ed; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #2;
  endtask

  function automatic logic [15:0] m(input int a);
    return 16'(1) << a;
  endfunction

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    r.owner = 0; r.busy = 0; r.done = 0; r.tag = "R2 reset state";
    compare(r);

    step('0,            0, 1, 0, 2'b00, 0,  0, 0, "R3 idle default");
    step(m(3)|m(5),     0, 1, 0, 2'b00, 3,  0, 0, "R10 R4 first pick");
    step(m(3)|m(5),     1, 3, 1, 2'b00, 3,  1, 0, "R6 start burst of 3");
    step(m(3)|m(5),     0, 3, 1, 2'b00, 3,  1, 0, "R8 beat 1");
    step(m(3)|m(5),     0, 3, 0, 2'b00, 3,  1, 0, "R8 wait state stalls");
    step(m(3)|m(5),     0, 3, 1, 2'b00, 3,  1, 0, "R8 beat 2");
    step(m(3)|m(5),     0, 3, 1, 2'b00, 5,  0, 1, "R5 R8 R4 handover at last beat");
    step(m(3)|m(5),     0, 1, 0, 2'b00, 5,  0, 0, "R11 owner keeps grant");
    step(m(3),          0, 1, 0, 2'b00, 3,  0, 0, "R10 R4 owner drops, wrap");
    step(m(15)|m(2),    0, 1, 0, 2'b00, 15, 0, 0, "R4 picks 15 before 2");
    step(m(15)|m(2),    1, 1, 0, 2'b00, 15, 1, 0, "R6 single transfer");
    step(m(2),          0, 1, 0, 2'b00, 15, 1, 0, "R7 hold despite dropped request");
    step(m(2),          0, 1, 1, 2'b00, 2,  0, 1, "R8 R4 single beat done, wrap to 2");
    step(m(2)|m(7),     1, 4, 1, 2'b00, 2,  1, 0, "R6 start burst of 4");
    step(m(2)|m(7),     0, 4, 1, 2'b01, 7,  0, 1, "R9 error ends burst early");
    step('0,            1, 2, 1, 2'b00, 0,  0, 0, "R10 R3 start ignored, default");
    step(m(0),          1, 2, 1, 2'b00, 0,  1, 0, "R6 default master transfers");
    step(m(0)|m(1),     0, 2, 1, 2'b00, 0,  1, 0, "R8 beat 1 of 2");
    step(m(0)|m(1),     0, 2, 1, 2'b00, 0,  0, 1, "R4 pointer kept past default grant");
    step(m(0)|m(1),     0, 1, 0, 2'b00, 0,  0, 0, "R11 hold while requesting");
    step(m(1),          0, 1, 0, 2'b00, 1,  0, 0, "R10 drop hands to 1");
    step('0,            0, 1, 0, 2'b00, 0,  0, 0, "R3 back to default");
    step(m(0),          1, 0, 1, 2'b00, 0,  1, 0, "R6 zero length start");
    step(m(0),          0, 0, 1, 2'b00, 0,  0, 1, "R6 zero length acts as one");

    // full rotation with every master requesting, single-beat transfers
    for (int k = 1; k <= N; k++) begin
      step('1, 1, 1, 1, 2'b00, (k - 1) % N, 1, 0, "R6 rotation start");
      step('1, 0, 1, 1, 2'b00, k % N,       0, 1, "R4 R5 R1 rotation handover");
    end

    step('0, 0, 1, 0, 2'b00, 0, 0, 0, "R3 final park");
    @(posedge clk);
    #3;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // watchdog
  initial begin
    #400000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule